// File: doc/BRIEF.md
# Register Rename Table with Free List

This block renames registers at the decode stage of an out-of-order core that has more physical than architectural registers. A map table holds, for every architectural register, the physical register that names its newest version. A circular free list holds the physical registers that no live version uses. Each decoded instruction presents two architectural sources and, optionally, one architectural destination. The block returns the physical tags of both sources, a fresh physical tag for the destination, and the tag that the destination mapped to before this instruction.

The pipeline keeps that previous tag with the instruction. When the instruction retires, the pipeline passes the tag back through the commit port, and the block appends it to the free list. The tag handed out to an instruction is never the one freed at that instruction's own retirement.

One checkpoint of the map table and of the free-list read position can be held at a time. A restore pulse reloads the checkpoint in a single cycle and so discards every rename made after it. Tracking of operand readiness and the register file storage belong to other blocks.

Top module: `rn_rename`

## Requirements
- R1: The source tag outputs are combinational lookups of the current map table, one entry per architectural register. They are valid in every cycle, whether or not a decode is presented.
- R2: An instruction whose source is also its own destination receives the mapping as it stood before that instruction, not its own new tag.
- R3: An accepted decode with a destination takes the tag at the head of the free list and shows it on `dst_phys_o` in the same cycle. From the next cycle on, that architectural register reads as the new tag, which always differs from the previous mapping.
- R4: A decode without a destination (`dst_valid_i` low) allocates nothing. The next destination decode receives the same head tag.
- R5: `stall_o` is high exactly when `dec_valid_i` and `dst_valid_i` are high and the free list is empty at the start of the cycle; a commit in the same cycle does not lift it. A stalled decode changes neither the table nor the free list.
- R6: `dst_old_phys_o` equals the mapping that the destination register had before the decode.
- R7: A commit appends `commit_phys_i` to the tail of the free list. Tags leave the list in the order they entered it.
- R8: `ckpt_i` records the table and the free-list read position, including the decode of the same cycle. `restore_i` reloads both in one cycle. A decode in the restore cycle is dropped, and a commit in the restore cycle still takes effect.
- R9: After reset, architectural register i maps to physical register i. The free list holds NUM_ARCH up to NUM_PHYS-1 in ascending order, with the lowest at the head.
- R10: A checkpoint requested in the same cycle as a restore is ignored, so the earlier checkpoint stays in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid_i | input | 1 | A decoded instruction is presented |
| src0_arch_i | input | log2(NUM_ARCH) | First source architectural register |
| src1_arch_i | input | log2(NUM_ARCH) | Second source architectural register |
| dst_valid_i | input | 1 | The instruction writes a register |
| dst_arch_i | input | log2(NUM_ARCH) | Destination architectural register |
| src0_phys_o | output | log2(NUM_PHYS) | Physical tag of the first source |
| src1_phys_o | output | log2(NUM_PHYS) | Physical tag of the second source |
| dst_phys_o | output | log2(NUM_PHYS) | Newly allocated destination tag (free-list head) |
| dst_old_phys_o | output | log2(NUM_PHYS) | Previous mapping of the destination |
| stall_o | output | 1 | Decode must be held: no free tag |
| commit_valid_i | input | 1 | A retired tag is returned |
| commit_phys_i | input | log2(NUM_PHYS) | Tag to append to the free list |
| ckpt_i | input | 1 | Record the checkpoint |
| restore_i | input | 1 | Reload the checkpoint, dropping later renames |

## Verification
Three pairs of operations can land in the same cycle: a retirement can meet a decode, and a restore can meet either a retirement or a checkpoint request. The bench drives a retirement into a cycle whose decode stalls on an empty list, then a restore alongside a retirement and a decode, then a restore alongside a checkpoint. A long random phase mixes all of these. In every cycle a behavioural model built from queues predicts the tags, the stall and the post-restore mapping, and the bench compares its predictions with the outputs.

// File: rtl/rn_pkg.sv
package rn_pkg;
    localparam int RN_NUM_ARCH_DEF = 8;
    localparam int RN_NUM_PHYS_DEF = 16;
endpackage

// File: rtl/rn_map_table.sv
module rn_map_table #(
    parameter int NUM_ARCH = rn_pkg::RN_NUM_ARCH_DEF,
    parameter int NUM_PHYS = rn_pkg::RN_NUM_PHYS_DEF,
    localparam int AW = $clog2(NUM_ARCH),
    localparam int PW = $clog2(NUM_PHYS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd0_arch,
    input  logic [AW-1:0] rd1_arch,
    input  logic [AW-1:0] rd2_arch,
    output logic [PW-1:0] rd0_phys,
    output logic [PW-1:0] rd1_phys,
    output logic [PW-1:0] rd2_phys,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_arch,
    input  logic [PW-1:0] wr_phys,
    input  logic          ckpt,
    input  logic          restore
);
    typedef struct packed {
        logic [NUM_ARCH-1:0][PW-1:0] map;
        logic [NUM_ARCH-1:0][PW-1:0] snap;
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    // reads use the registered table: lookups precede the same-cycle write
    assign rd0_phys = tbl_q.map[rd0_arch];
    assign rd1_phys = tbl_q.map[rd1_arch];
    assign rd2_phys = tbl_q.map[rd2_arch];

    always_comb begin
        tbl_d = tbl_q;
        if (restore) begin
            tbl_d.map = tbl_q.snap;
        end else begin
            if (wr_en) tbl_d.map[wr_arch] = wr_phys;
            if (ckpt)  tbl_d.snap = tbl_d.map;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ARCH; i++) begin
                tbl_q.map[i]  <= PW'(i);
                tbl_q.snap[i] <= PW'(i);
            end
        end else begin
            tbl_q <= tbl_d;
        end
    end
endmodule

// File: rtl/rn_free_list.sv
module rn_free_list #(
    parameter int NUM_ARCH = rn_pkg::RN_NUM_ARCH_DEF,
    parameter int NUM_PHYS = rn_pkg::RN_NUM_PHYS_DEF,
    localparam int PW = $clog2(NUM_PHYS),
    localparam int NUM_FREE0 = NUM_PHYS - NUM_ARCH
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_en,
    output logic [PW-1:0] head_tag,
    output logic          empty,
    input  logic          free_en,
    input  logic [PW-1:0] free_tag,
    input  logic          ckpt,
    input  logic          restore
);
    typedef struct packed {
        logic [NUM_PHYS-1:0][PW-1:0] slot;
        logic [PW:0]                 head;
        logic [PW:0]                 tail;
        logic [PW:0]                 snap_head;
    } fl_t;

    fl_t fl_d, fl_q;

    assign head_tag = fl_q.slot[fl_q.head[PW-1:0]];
    assign empty    = (fl_q.head == fl_q.tail);

    always_comb begin
        fl_d = fl_q;
        if (free_en) begin
            fl_d.slot[fl_q.tail[PW-1:0]] = free_tag;
            fl_d.tail = fl_q.tail + (PW+1)'(1);
        end
        if (restore) begin
            fl_d.head = fl_q.snap_head;
        end else begin
            if (alloc_en) fl_d.head = fl_q.head + (PW+1)'(1);
            if (ckpt)     fl_d.snap_head = fl_d.head;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_PHYS; i++) begin
                fl_q.slot[i] <= (i < NUM_FREE0) ? PW'(NUM_ARCH + i) : '0;
            end
            fl_q.head      <= '0;
            fl_q.tail      <= (PW+1)'(NUM_FREE0);
            fl_q.snap_head <= '0;
        end else begin
            fl_q <= fl_d;
        end
    end
endmodule

// File: rtl/rn_rename.sv
module rn_rename #(
    parameter int NUM_ARCH = rn_pkg::RN_NUM_ARCH_DEF,
    parameter int NUM_PHYS = rn_pkg::RN_NUM_PHYS_DEF,
    localparam int AW = $clog2(NUM_ARCH),
    localparam int PW = $clog2(NUM_PHYS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dec_valid_i,
    input  logic [AW-1:0] src0_arch_i,
    input  logic [AW-1:0] src1_arch_i,
    input  logic          dst_valid_i,
    input  logic [AW-1:0] dst_arch_i,
    output logic [PW-1:0] src0_phys_o,
    output logic [PW-1:0] src1_phys_o,
    output logic [PW-1:0] dst_phys_o,
    output logic [PW-1:0] dst_old_phys_o,
    output logic          stall_o,
    input  logic          commit_valid_i,
    input  logic [PW-1:0] commit_phys_i,
    input  logic          ckpt_i,
    input  logic          restore_i
);
    logic fl_empty;
    logic want_dst;
    logic alloc;

    assign want_dst = dec_valid_i && dst_valid_i;
    assign stall_o  = want_dst && fl_empty;
    assign alloc    = want_dst && !fl_empty && !restore_i;

    rn_map_table #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd0_arch (src0_arch_i),
        .rd1_arch (src1_arch_i),
        .rd2_arch (dst_arch_i),
        .rd0_phys (src0_phys_o),
        .rd1_phys (src1_phys_o),
        .rd2_phys (dst_old_phys_o),
        .wr_en    (alloc),
        .wr_arch  (dst_arch_i),
        .wr_phys  (dst_phys_o),
        .ckpt     (ckpt_i),
        .restore  (restore_i)
    );

    rn_free_list #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_free (
        .clk      (clk),
        .rst_n    (rst_n),
        .alloc_en (alloc),
        .head_tag (dst_phys_o),
        .empty    (fl_empty),
        .free_en  (commit_valid_i),
        .free_tag (commit_phys_i),
        .ckpt     (ckpt_i),
        .restore  (restore_i)
    );
endmodule

// File: rtl/rn_rename_chk.sv
module rn_rename_chk #(
    parameter int NUM_ARCH = rn_pkg::RN_NUM_ARCH_DEF,
    parameter int NUM_PHYS = rn_pkg::RN_NUM_PHYS_DEF,
    localparam int AW = $clog2(NUM_ARCH),
    localparam int PW = $clog2(NUM_PHYS)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          dec_valid_i,
    input logic [AW-1:0] src0_arch_i,
    input logic          dst_valid_i,
    input logic [AW-1:0] dst_arch_i,
    input logic [PW-1:0] src0_phys_o,
    input logic [PW-1:0] dst_phys_o,
    input logic [PW-1:0] dst_old_phys_o,
    input logic          stall_o,
    input logic          commit_valid_i,
    input logic          restore_i
);
    logic took;
    assign took = dec_valid_i && dst_valid_i && !stall_o && !restore_i;

    AST_SRC_SEES_NEW: assert property (@(posedge clk) disable iff (!rst_n)
        took |=> (!(dec_valid_i && src0_arch_i == $past(dst_arch_i)) ||
                  src0_phys_o == $past(dst_phys_o)));  // R3
    AST_NEW_NOT_OLD: assert property (@(posedge clk) disable iff (!rst_n)
        took |-> dst_phys_o != dst_old_phys_o);  // R3
    AST_OLD_IS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        took |=> (!(dec_valid_i && dst_valid_i && dst_arch_i == $past(dst_arch_i)) ||
                  dst_old_phys_o == $past(dst_phys_o)));  // R6
    AST_NO_DEST_KEEPS_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!(dec_valid_i && dst_valid_i) && !commit_valid_i && !restore_i) |=> $stable(dst_phys_o));  // R4
    AST_STALL_NEEDS_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        stall_o |-> (dec_valid_i && dst_valid_i));  // R5
endmodule

bind rn_rename rn_rename_chk #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_chk (.*);

// File: tb/rn_rename_test.sv
module rn_rename_test;
    localparam int NA = 8;
    localparam int NP = 16;
    localparam int AW = $clog2(NA);
    localparam int PW = $clog2(NP);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dec_valid_i = 1'b0;
    logic [AW-1:0] src0_arch_i = '0;
    logic [AW-1:0] src1_arch_i = '0;
    logic          dst_valid_i = 1'b0;
    logic [AW-1:0] dst_arch_i = '0;
    logic [PW-1:0] src0_phys_o, src1_phys_o, dst_phys_o, dst_old_phys_o;
    logic          stall_o;
    logic          commit_valid_i = 1'b0;
    logic [PW-1:0] commit_phys_i = '0;
    logic          ckpt_i = 1'b0;
    logic          restore_i = 1'b0;

    always #4 clk = ~clk;

    rn_rename #(.NUM_ARCH(NA), .NUM_PHYS(NP)) uut (.*);

    int n_chk = 0;
    int n_fail = 0;

    // behavioural model
    int mdl_map[NA];
    int snap_map[NA];
    int mdl_fl[$];
    int snap_fl[$];
    int pend[$];
    int spec_cnt = 0;

    task automatic chk(input string lbl, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", lbl, act, exp);
        end
    endtask

    task automatic step(input bit dv, input int s0, input int s1, input bit ddv, input int d,
                        input bit cv, input int ct, input bit ck, input bit rs, input string req);
        bit exp_stall;
        bit took;
        int new_tag;
        @(negedge clk);
        dec_valid_i    = dv;
        src0_arch_i    = AW'(s0);
        src1_arch_i    = AW'(s1);
        dst_valid_i    = ddv;
        dst_arch_i     = AW'(d);
        commit_valid_i = cv;
        commit_phys_i  = PW'(ct);
        ckpt_i         = ck;
        restore_i      = rs;
        #2;
        exp_stall = dv && ddv && (mdl_fl.size() == 0);
        took = dv && ddv && !exp_stall && !rs;
        chk({req, " stall"}, int'(stall_o), int'(exp_stall));
        chk({req, " src0"}, int'(src0_phys_o), mdl_map[s0]);
        chk({req, " src1"}, int'(src1_phys_o), mdl_map[s1]);
        if (took) begin
            chk({req, " dst_new"}, int'(dst_phys_o), mdl_fl[0]);
            chk({req, " dst_old"}, int'(dst_old_phys_o), mdl_map[d]);
        end
        // model update at the coming edge
        if (cv) begin
            mdl_fl.push_back(ct);
            snap_fl.push_back(ct);
        end
        if (rs) begin
            mdl_map = snap_map;
            mdl_fl  = snap_fl;
            repeat (spec_cnt) void'(pend.pop_back());
            spec_cnt = 0;
        end else begin
            if (took) begin
                new_tag = mdl_fl.pop_front();
                pend.push_back(mdl_map[d]);
                spec_cnt++;
                mdl_map[d] = new_tag;
            end
            if (ck) begin
                snap_map = mdl_map;
                snap_fl  = mdl_fl;
                spec_cnt = 0;
            end
        end
    endtask

    task automatic idle(input string req);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, req);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #(8 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        int ct;
        for (int i = 0; i < NA; i++) begin
            mdl_map[i] = i;
        end
        for (int i = NA; i < NP; i++) mdl_fl.push_back(i);
        snap_map = mdl_map;
        snap_fl  = mdl_fl;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9: identity mapping after reset, R1 lookups without decode
        for (int i = 0; i < NA; i++) step(0, i, NA - 1 - i, 0, 0, 0, 0, 0, 0, "R9");
        // R3/R9: first allocation takes the lowest free tag
        step(1, 0, 0, 1, 1, 0, 0, 0, 0, "R3");
        chk("R9 first_tag", int'(mdl_map[1]), NA);
        step(1, 1, 1, 0, 0, 0, 0, 0, 0, "R3");
        // R2: read and write the same register
        step(1, 2, 2, 1, 2, 0, 0, 0, 0, "R2");
        step(1, 2, 1, 0, 0, 0, 0, 0, 0, "R2");
        // R4: no destination, then the head tag is still next
        step(1, 3, 4, 0, 5, 0, 0, 0, 0, "R4");
        step(1, 3, 4, 1, 5, 0, 0, 0, 0, "R4");
        // R6: same destination twice in a row
        step(1, 5, 5, 1, 5, 0, 0, 0, 0, "R6");
        // R5: drain the free list, then stall
        while (mdl_fl.size() > 0) step(1, 6, 7, 1, 6, 0, 0, 0, 0, "R5");
        step(1, 6, 7, 1, 7, 0, 0, 0, 0, "R5");
        step(1, 7, 6, 0, 0, 0, 0, 0, 0, "R5");
        // R5/R7: commit in the stalled cycle does not lift the stall
        ct = pend.pop_front();
        step(1, 1, 2, 1, 3, 1, ct, 0, 0, "R5");
        step(1, 1, 2, 1, 3, 0, 0, 0, 0, "R7");
        chk("R7 fifo_reuse", mdl_map[3], ct);
        // R7: two commits then two allocations keep order
        ct = pend.pop_front();
        step(0, 0, 0, 0, 0, 1, ct, 0, 0, "R7");
        ct = pend.pop_front();
        step(0, 0, 0, 0, 0, 1, ct, 0, 0, "R7");
        step(1, 4, 4, 1, 4, 0, 0, 0, 0, "R7");
        step(1, 4, 4, 1, 0, 0, 0, 0, 0, "R7");
        // R8: checkpoint with a same-cycle decode, speculate, restore with commit and decode
        ct = pend.pop_front();
        step(0, 0, 0, 0, 0, 1, ct, 0, 0, "R8");
        step(1, 0, 1, 1, 2, 0, 0, 1, 0, "R8");
        step(1, 2, 2, 1, 3, 0, 0, 0, 0, "R8");
        ct = pend.pop_front();
        step(1, 3, 3, 1, 4, 1, ct, 0, 1, "R8");
        for (int i = 0; i < NA; i++) step(0, i, i, 0, 0, 0, 0, 0, 0, "R8");
        step(1, 0, 0, 1, 6, 0, 0, 0, 0, "R8");
        // R10: checkpoint in a restore cycle is ignored
        step(1, 6, 6, 1, 1, 0, 0, 1, 1, "R10");
        step(1, 6, 6, 1, 2, 0, 0, 0, 0, "R10");
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, "R10");
        for (int i = 0; i < NA; i++) step(0, i, i, 0, 0, 0, 0, 0, 0, "R10");

        // random mix of all operations
        for (int n = 0; n < 4000; n++) begin
            bit cv;
            int tag;
            cv = 1'b0;
            tag = 0;
            if (pend.size() > spec_cnt && $urandom_range(0, 99) < 40) begin
                cv = 1'b1;
                tag = pend.pop_front();
            end
            step($urandom_range(0, 99) < 80, $urandom_range(0, NA - 1), $urandom_range(0, NA - 1),
                 $urandom_range(0, 99) < 70, $urandom_range(0, NA - 1), cv, tag,
                 $urandom_range(0, 99) < 6, $urandom_range(0, 99) < 3, "R1");
        end
        summary();
        $finish;
    end
endmodule